// File: doc/BRIEF.md
# Local Interrupt Priority Dispatcher

This block sits between the interrupt message fabric and a processor core. It takes in interrupt messages, each with a 3-bit delivery mode and an 8-bit vector. It also takes five dedicated special-event lines. It keeps every request pending until the core takes it, and always offers the core the single most urgent one. Special events are ranked in a fixed order: cache flush is highest, then stop clock, SMI, INIT and NMI. Every vectored (fixed-mode) request ranks below all of the special events. Fixed requests are ranked by vector number, so a larger vector wins. The upper four bits of the vector give its priority class.

A fixed message whose vector is in the reserved range 0 to 15 does not become pending. Instead it sets a sticky error bit, and that bit stays set until the error-clear strobe clears it. One global enable, driven by core-side disable and enable commands, holds back all fixed requests together. The special events are never held back by it. The core sees a request flag, the kind of request and, for fixed requests, its vector. The core pulses acknowledge to retire the request it is being shown.

Top module: `intr_prio_dispatch`

## Requirements
- R1: Pending special events are presented in the order flush, stop clock, SMI, INIT, NMI, highest first. Any pending special event is presented ahead of every fixed request. `core_kind` encodes 0 none, 1 fixed, 2 NMI, 3 INIT, 4 SMI, 5 stop clock, 6 flush.
- R2: An acknowledge while `core_req` is high retires only the request being shown. From the next cycle the next most urgent request is shown. An acknowledge while `core_req` is low has no effect.
- R3: Among pending fixed requests, the one with the larger vector is shown first. Vector 255 is the highest and vector 16 the lowest. `core_vector` carries the vector for kind fixed and is 0 for any other kind.
- R4: A fixed-mode message (mode 000) with vector 0–15 pends nothing and sets `err_rx_illegal`. A fixed-mode message with vector 16–31 pends like any other vector and raises no error.
- R5: `err_rx_illegal` stays set until `err_clr` is pulsed. If an illegal vector arrives in the same cycle as `err_clr`, the bit stays set.
- R6: Modes 010 (SMI), 100 (NMI) and 101 (INIT with `msg_deassert` low) pend the matching special event and ignore the vector, so they never set the error bit. Modes 110 (startup) and 111 (ExtINT), INIT with `msg_deassert` high, and the unused codes 001 and 011 change no state.
- R7: The global enable is off after reset. `ien_set` turns it on and `ien_clr` turns it off, and `ien_clr` wins when both are pulsed together. While the enable is off, no fixed request is shown, but fixed requests keep pending. Special events are shown whatever the enable is.
- R8: A repeated message for a vector that is already pending merges with it, so a single acknowledge retires it.
- R9: A fixed message for the vector being acknowledged in the same cycle leaves that vector pending.
- R10: After reset nothing is pending, `core_req` is 0, `core_kind` is 0, `core_vector` is 0 and `err_rx_illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | Message strobe |
| msg_mode | input | 3 | Delivery mode of the message |
| msg_vector | input | 8 | Vector of the message |
| msg_deassert | input | 1 | Marks an INIT message as a deassert |
| flush_in | input | 1 | Cache-flush event pulse |
| stop_in | input | 1 | Stop-clock event pulse |
| smi_in | input | 1 | SMI event pulse |
| init_in | input | 1 | INIT event pulse |
| nmi_in | input | 1 | NMI event pulse |
| ien_set | input | 1 | Enable-fixed-interrupts command |
| ien_clr | input | 1 | Disable-fixed-interrupts command |
| core_ack | input | 1 | Core takes the presented request |
| core_req | output | 1 | A request is being presented |
| core_kind | output | 3 | Kind of the presented request |
| core_vector | output | 8 | Vector of a presented fixed request |
| err_clr | input | 1 | Clears the error bits |
| err_rx_illegal | output | 1 | Sticky received-illegal-vector flag |

## Verification
Two functions can fall in the same cycle: the arrival of a fixed message and the core's acknowledge of that same vector. A second such pair is an illegal-vector arrival and the error clear. The bench provokes the first pair by driving a message for the vector currently shown while acknowledge is high. It judges that the vector is still presented in the next cycle. The second pair is provoked by driving a reserved vector together with `err_clr`, and it is judged by the error bit still being set. Sweeps over all 256 vectors, over all 32 combinations of special lines, and over many vector pairs compute the expected order arithmetically.

// File: rtl/ipd_pkg.sv
package ipd_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_FIXED = 3'd1,
    K_NMI   = 3'd2,
    K_INIT  = 3'd3,
    K_SMI   = 3'd4,
    K_STOP  = 3'd5,
    K_FLUSH = 3'd6
  } kind_e;

  localparam logic [2:0] MODE_FIXED  = 3'b000;
  localparam logic [2:0] MODE_SMI    = 3'b010;
  localparam logic [2:0] MODE_NMI    = 3'b100;
  localparam logic [2:0] MODE_INIT   = 3'b101;
  localparam logic [2:0] MODE_START  = 3'b110;
  localparam logic [2:0] MODE_EXTINT = 3'b111;

  // number of special sources; bit index 0 is the lowest ranked (NMI)
  localparam int NSPEC = 5;

  function automatic logic vec_is_illegal(input int v, input int lim);
    return v < lim;
  endfunction

  function automatic int vec_class(input int v, input int grp_w);
    return v >> grp_w;
  endfunction

  function automatic kind_e spec_kind(input int idx);
    return kind_e'(idx + 2);
  endfunction
endpackage

// File: rtl/ipd_msg_decode.sv
module ipd_msg_decode
  import ipd_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int ILL_LIM = 16
) (
  input  logic             valid,
  input  logic [2:0]       mode,
  input  logic [VEC_W-1:0] vector,
  input  logic             deassert,
  output logic             fix_set,
  output logic [VEC_W-1:0] fix_vec,
  output logic             ill_set,
  output logic             smi_set,
  output logic             init_set,
  output logic             nmi_set
);
  logic is_fixed;
  logic illegal;

  assign is_fixed = valid && (mode == MODE_FIXED);
  assign illegal  = vec_is_illegal(int'(vector), ILL_LIM);

  always_comb begin
    fix_set  = is_fixed && !illegal;
    ill_set  = is_fixed && illegal;
    fix_vec  = vector;
    smi_set  = 1'b0;
    init_set = 1'b0;
    nmi_set  = 1'b0;
    if (valid) begin
      unique case (mode)
        MODE_SMI:  smi_set  = 1'b1;
        MODE_NMI:  nmi_set  = 1'b1;
        MODE_INIT: init_set = !deassert;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/ipd_vec_pend.sv
module ipd_vec_pend #(
  parameter int VEC_W = 8,
  parameter int GRP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [VEC_W-1:0] set_vec,
  input  logic             clr_en,
  input  logic [VEC_W-1:0] clr_vec,
  output logic [(1<<VEC_W)-1:0] pend,
  output logic             any,
  output logic [VEC_W-1:0] top_vec
);
  localparam int N     = 1 << VEC_W;
  localparam int G     = 1 << GRP_W;
  localparam int NC    = N / G;
  localparam int CLS_W = VEC_W - GRP_W;

  logic [N-1:0]     set_mask, clr_mask;
  logic [NC-1:0]    cls_any;
  logic [GRP_W-1:0] cls_top [NC];
  logic [CLS_W-1:0] top_cls;

  assign set_mask = set_en ? (N'(1) << set_vec) : '0;
  assign clr_mask = clr_en ? (N'(1) << clr_vec) : '0;

  // a new arrival outranks the retire of the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | set_mask;
  end

  for (genvar c = 0; c < NC; c++) begin : g_cls
    assign cls_any[c] = |pend[c*G +: G];
    always_comb begin
      cls_top[c] = '0;
      for (int b = 0; b < G; b++)
        if (pend[c*G + b]) cls_top[c] = GRP_W'(b);
    end
  end

  always_comb begin
    top_cls = '0;
    for (int c = 0; c < NC; c++)
      if (cls_any[c]) top_cls = CLS_W'(c);
  end

  assign any     = |cls_any;
  assign top_vec = {top_cls, cls_top[top_cls]};
endmodule

// File: rtl/ipd_special_arb.sv
module ipd_special_arb
  import ipd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSPEC-1:0] set_bits,
  input  logic             clr_en,
  output logic [NSPEC-1:0] pend,
  output logic             any,
  output kind_e            sel_kind
);
  logic [NSPEC-1:0] top_onehot;

  always_comb begin
    top_onehot = '0;
    sel_kind   = K_NONE;
    for (int i = 0; i < NSPEC; i++)
      if (pend[i]) begin
        top_onehot = NSPEC'(1) << i;
        sel_kind   = spec_kind(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~(clr_en ? top_onehot : '0)) | set_bits;
  end

  assign any = |pend;
endmodule

// File: rtl/intr_prio_dispatch.sv
module intr_prio_dispatch
  import ipd_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int GRP_W   = 4,
  parameter int ILL_LIM = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [2:0]       msg_mode,
  input  logic [VEC_W-1:0] msg_vector,
  input  logic             msg_deassert,
  input  logic             flush_in,
  input  logic             stop_in,
  input  logic             smi_in,
  input  logic             init_in,
  input  logic             nmi_in,
  input  logic             ien_set,
  input  logic             ien_clr,
  input  logic             core_ack,
  output logic             core_req,
  output logic [2:0]       core_kind,
  output logic [VEC_W-1:0] core_vector,
  input  logic             err_clr,
  output logic             err_rx_illegal
);
  localparam int N = 1 << VEC_W;

  logic             fix_set, ill_set, smi_set, init_set, nmi_set;
  logic [VEC_W-1:0] fix_vec, top_vec;
  logic [N-1:0]     fix_pend;
  logic             fix_any, spec_any;
  logic [NSPEC-1:0] spec_set, spec_pend;
  kind_e            spec_kind_sel, kind_sel;
  logic             ien_q, ack_fire, spec_retire, fix_retire;

  ipd_msg_decode #(.VEC_W(VEC_W), .ILL_LIM(ILL_LIM)) u_dec (
    .valid(msg_valid), .mode(msg_mode), .vector(msg_vector),
    .deassert(msg_deassert), .fix_set(fix_set), .fix_vec(fix_vec),
    .ill_set(ill_set), .smi_set(smi_set), .init_set(init_set),
    .nmi_set(nmi_set)
  );

  // bit order follows rank: index 4 is the most urgent
  assign spec_set = {flush_in, stop_in, smi_in | smi_set,
                     init_in | init_set, nmi_in | nmi_set};

  ipd_special_arb u_spec (
    .clk(clk), .rst_n(rst_n), .set_bits(spec_set), .clr_en(spec_retire),
    .pend(spec_pend), .any(spec_any), .sel_kind(spec_kind_sel)
  );

  ipd_vec_pend #(.VEC_W(VEC_W), .GRP_W(GRP_W)) u_fix (
    .clk(clk), .rst_n(rst_n), .set_en(fix_set), .set_vec(fix_vec),
    .clr_en(fix_retire), .clr_vec(top_vec), .pend(fix_pend),
    .any(fix_any), .top_vec(top_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ien_q <= 1'b0;
    else if (ien_clr) ien_q <= 1'b0;
    else if (ien_set) ien_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_rx_illegal <= 1'b0;
    else if (ill_set) err_rx_illegal <= 1'b1;
    else if (err_clr) err_rx_illegal <= 1'b0;
  end

  always_comb begin
    if (spec_any)             kind_sel = spec_kind_sel;
    else if (ien_q && fix_any) kind_sel = K_FIXED;
    else                      kind_sel = K_NONE;
  end

  assign core_req    = (kind_sel != K_NONE);
  assign core_kind   = kind_sel;
  assign core_vector = (kind_sel == K_FIXED) ? top_vec : '0;
  assign ack_fire    = core_ack && core_req;
  assign spec_retire = ack_fire && spec_any;
  assign fix_retire  = ack_fire && !spec_any;
endmodule

// File: rtl/ipd_checker.sv
module ipd_checker #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic [2:0]       msg_mode,
  input logic [VEC_W-1:0] msg_vector,
  input logic             flush_in,
  input logic             core_ack,
  input logic             core_req,
  input logic [2:0]       core_kind,
  input logic [VEC_W-1:0] core_vector,
  input logic             err_clr,
  input logic             err_rx_illegal,
  input logic [4:0]       spec_pend,
  input logic             ien_q,
  input logic [(1<<VEC_W)-1:0] fix_pend
);
  AST_FLUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    spec_pend[4] |-> core_kind == 3'd6); // R1
  AST_SPEC_OVER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_pend != '0) |-> core_kind != 3'd1); // R1
  AST_FLUSH_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    core_ack && core_req && core_kind == 3'd6 && !flush_in |=> !spec_pend[4]); // R2
  AST_FIXED_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    core_kind == 3'd1 |-> core_vector >= VEC_W'(16) && fix_pend[core_vector]); // R3
  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_mode == 3'b000 && msg_vector < VEC_W'(16) |=> err_rx_illegal); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_rx_illegal && !err_clr |=> err_rx_illegal); // R5
  AST_GATE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q |-> core_kind != 3'd1); // R7
  AST_ARRIVAL_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_mode == 3'b000 && msg_vector >= VEC_W'(16)
    |=> fix_pend[$past(msg_vector)]); // R9
endmodule

bind intr_prio_dispatch ipd_checker #(.VEC_W(VEC_W)) u_ipd_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_mode(msg_mode),
  .msg_vector(msg_vector), .flush_in(flush_in), .core_ack(core_ack),
  .core_req(core_req), .core_kind(core_kind), .core_vector(core_vector),
  .err_clr(err_clr), .err_rx_illegal(err_rx_illegal), .spec_pend(spec_pend),
  .ien_q(ien_q), .fix_pend(fix_pend)
);

// File: tb/intr_prio_dispatch_test.sv
module intr_prio_dispatch_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       msg_valid = 0, msg_deassert = 0;
  logic [2:0] msg_mode = 0;
  logic [7:0] msg_vector = 0;
  logic       flush_in = 0, stop_in = 0, smi_in = 0, init_in = 0, nmi_in = 0;
  logic       ien_set = 0, ien_clr = 0, core_ack = 0, err_clr = 0;
  logic       core_req, err_rx_illegal;
  logic [2:0] core_kind;
  logic [7:0] core_vector;
  int checks = 0, errors = 0;
  bit done = 0;

  intr_prio_dispatch uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_out(input string tag, input int kind, input int vec);
    chk(core_kind == kind, {tag, " kind"}, core_kind, kind);
    chk(core_req == (kind != 0), {tag, " req"}, core_req, kind != 0);
    chk(core_vector == vec, {tag, " vector"}, core_vector, vec);
  endtask

  task automatic send(input logic [2:0] m, input int v, input bit d);
    msg_valid = 1; msg_mode = m; msg_vector = 8'(v); msg_deassert = d;
    tick();
    msg_valid = 0; msg_deassert = 0;
  endtask

  task automatic ack();
    core_ack = 1; tick(); core_ack = 0;
  endtask

  task automatic clear_err();
    err_clr = 1; tick(); err_clr = 0;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_sim();
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R10: reset state
    expect_out("R10 reset", 0, 0);
    chk(err_rx_illegal == 0, "R10 err", err_rx_illegal, 0);
    rst_n = 1; tick();

    // R7: enable off after reset, fixed still pends, special not gated
    send(3'b000, 100, 0);
    expect_out("R7 gated", 0, 0);
    nmi_in = 1; tick(); nmi_in = 0;
    expect_out("R7 nmi ungated", 2, 0);
    ack();
    expect_out("R7 nmi retired", 0, 0);
    ien_set = 1; tick(); ien_set = 0;
    expect_out("R7 enable shows kept", 1, 100);
    ien_set = 1; ien_clr = 1; tick(); ien_set = 0; ien_clr = 0;
    expect_out("R7 clr wins", 0, 0);
    ien_set = 1; tick(); ien_set = 0;
    // R8: repeated message merges
    send(3'b000, 100, 0);
    ack();
    expect_out("R8 merged", 0, 0);

    // R4 R3 R2: sweep every vector
    for (int v = 0; v < 256; v++) begin
      send(3'b000, v, 0);
      if (v < 16) begin
        expect_out("R4 illegal no pend", 0, 0);
        chk(err_rx_illegal == 1, "R4 illegal err", err_rx_illegal, 1);
        clear_err();
        chk(err_rx_illegal == 0, "R5 clear", err_rx_illegal, 0);
      end else begin
        expect_out("R4 legal pend", 1, v);
        chk(err_rx_illegal == 0, "R4 no err", err_rx_illegal, 0);
        ack();
        expect_out("R2 retired", 0, 0);
      end
    end

    // R2: ack with nothing presented is ignored
    ack();
    expect_out("R2 idle ack", 0, 0);

    // R3: pairs
    for (int a = 16; a < 256; a += 17) begin
      for (int b = 16; b < 256; b += 23) begin
        if (a != b) begin
          send(3'b000, a, 0);
          send(3'b000, b, 0);
          expect_out("R3 higher first", 1, (a > b) ? a : b);
          ack();
          expect_out("R3 lower next", 1, (a > b) ? b : a);
          ack();
        end
      end
    end

    // R1: all special combinations plus a fixed request
    for (int m = 0; m < 32; m++) begin
      send(3'b000, 200, 0);
      nmi_in = m[0]; init_in = m[1]; smi_in = m[2]; stop_in = m[3]; flush_in = m[4];
      tick();
      {nmi_in, init_in, smi_in, stop_in, flush_in} = '0;
      for (int i = 4; i >= 0; i--) begin
        if (m[i]) begin
          expect_out("R1 order", i + 2, 0);
          ack();
        end
      end
      expect_out("R1 fixed last", 1, 200);
      ack();
      expect_out("R1 drained", 0, 0);
    end

    // R6: mode decode, vector ignored
    send(3'b010, 5, 0);
    expect_out("R6 smi msg", 4, 0);
    chk(err_rx_illegal == 0, "R6 smi no err", err_rx_illegal, 0);
    send(3'b100, 3, 0);
    expect_out("R6 smi over nmi", 4, 0);
    ack();
    expect_out("R6 nmi after smi", 2, 0);
    ack();
    send(3'b101, 7, 0);
    expect_out("R6 init msg", 3, 0);
    ack();
    send(3'b101, 7, 1);
    send(3'b110, 2, 0);
    send(3'b111, 9, 0);
    send(3'b001, 40, 0);
    send(3'b011, 41, 0);
    expect_out("R6 no effect", 0, 0);
    chk(err_rx_illegal == 0, "R6 no err", err_rx_illegal, 0);

    // R9: arrival and retire of same vector
    send(3'b000, 60, 0);
    msg_valid = 1; msg_mode = 3'b000; msg_vector = 8'd60; core_ack = 1;
    tick();
    msg_valid = 0; core_ack = 0;
    expect_out("R9 still pending", 1, 60);
    ack();
    expect_out("R9 retired", 0, 0);

    // R5: sticky, and set wins over clear
    send(3'b000, 4, 0);
    repeat (3) tick();
    chk(err_rx_illegal == 1, "R5 sticky", err_rx_illegal, 1);
    msg_valid = 1; msg_mode = 3'b000; msg_vector = 8'd9; err_clr = 1;
    tick();
    msg_valid = 0; err_clr = 0;
    chk(err_rx_illegal == 1, "R5 set wins", err_rx_illegal, 1);
    clear_err();
    chk(err_rx_illegal == 0, "R5 cleared", err_rx_illegal, 0);

    done = 1;
    finish_sim();
  end
endmodule